// File: doc/BRIEF.md
# IDE DMA Strobe and Acknowledge Sequencer

This block runs the device-facing half of a bus-master transfer on a parallel IDE channel. While the channel is enabled and the drive requests service, it asserts the DMA acknowledge. It then issues a train of read or write strobes, one per data word. Each strobe has an active width and a recovery gap taken from a small timing register image. A per-word pulse tells the data path when a word has moved. Data buffering, descriptor handling and the memory side sit outside the block.

The timing image holds two mode selections: one shared with programmed I/O, and a faster one. A single flag decides whether DMA cycles use the faster mode while programmed I/O keeps the slower one. The drive's request is looked at only on the clock edge where a strobe goes inactive. If the request or the enable is low at that edge, acknowledge is released on the following clock and the burst is over. A new burst waits for the request to return.

Top module: `ide_dma_strobe_unit`

## Requirements
- R1: After reset, `dior_no`, `diow_no` and `dmack_no` are high and `xfer_o` is low.
- R2: With `en_i` and `dmarq_i` high while idle, `dmack_no` goes low and the first strobe goes low exactly one clock later. No strobe is ever low while `dmack_no` is high. With `en_i` low, no burst starts.
- R3: `dir_i` = 0 selects the read strobe `dior_no` and `dir_i` = 1 selects the write strobe `diow_no`. The other strobe stays high, so the two are never low together.
- R4: For a selected mode m (0..3), each strobe stays low for 5 - m clocks and the gap between strobes in a burst is 4 - m clocks.
- R5: Timing image layout: bits [1:0] hold the shared PIO mode, bits [3:2] hold the fast mode, and bit 4 is the DMA-only fast flag. DMA uses the fast mode when bit 4 is 1 and the PIO mode when it is 0.
- R6: `dmarq_i` is sampled only on the edge where a strobe deasserts. A request that drops and returns while a strobe is active does not end the burst.
- R7: If `dmarq_i` or `en_i` is low on a strobe-deassert edge, `dmack_no` is still low in the following clock and high in the one after it.
- R8: Once acknowledge has been released, no strobe and no acknowledge occur while the request stays low.
- R9: `xfer_o` pulses for exactly one clock, in the clock after each strobe deasserts, once per word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Channel engaged; gates burst start and continuation |
| dir_i | input | 1 | 0 = read from device, 1 = write to device |
| dmarq_i | input | 1 | Device DMA request, active high |
| timing_i | input | 5 | Timing image: [1:0] PIO mode, [3:2] fast mode, [4] DMA-only fast |
| dior_no | output | 1 | Read strobe, active low |
| diow_no | output | 1 | Write strobe, active low |
| dmack_no | output | 1 | DMA acknowledge, active low |
| xfer_o | output | 1 | One-clock pulse per transferred word |

## Verification
The sweep covers every pairing of PIO and fast mode, both settings of the DMA-only flag and both directions. Burst lengths are one to three words. Timing derived from the wrong field shows up as strobe and gap widths that miss the bench's arithmetic. In every multi-word burst the request is pulsed low in the middle of an active strobe. A design that samples the request on any edge other than the deassert edge cuts that burst short. The bench also checks the exact clock on which acknowledge is released, the quiet period after it, and the number of per-word pulses. These catch an acknowledge that drops early or late, a burst that restarts with no request, and a missing or doubled pulse.

// File: rtl/ide_dma_pkg.sv
package ide_dma_pkg;
  localparam int MODE_W = 2;

  typedef struct packed {
    logic              dma_fast_only;
    logic [MODE_W-1:0] fast_mode;
    logic [MODE_W-1:0] pio_mode;
  } tim_reg_t;

  localparam int TIM_W = $bits(tim_reg_t);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACK,
    ST_STRB,
    ST_REC,
    ST_HOLD
  } seq_st_e;
endpackage

// File: rtl/ide_tmg_sel.sv
module ide_tmg_sel
  import ide_dma_pkg::*;
#(
  parameter int ACT_MAX = 5,
  parameter int REC_MAX = 4,
  parameter int CNT_W   = 4
) (
  input  tim_reg_t         tim_i,
  output logic [CNT_W-1:0] act_o,
  output logic [CNT_W-1:0] rec_o
);
  localparam int NMODES = 1 << MODE_W;

  logic [CNT_W-1:0] act_tbl [NMODES];
  logic [CNT_W-1:0] rec_tbl [NMODES];
  logic [MODE_W-1:0] mode_sel;

  // faster mode -> fewer clocks in each phase
  for (genvar m = 0; m < NMODES; m++) begin : g_mode
    assign act_tbl[m] = CNT_W'(ACT_MAX - m);
    assign rec_tbl[m] = CNT_W'(REC_MAX - m);
  end

  assign mode_sel = tim_i.dma_fast_only ? tim_i.fast_mode : tim_i.pio_mode;
  assign act_o    = act_tbl[mode_sel];
  assign rec_o    = rec_tbl[mode_sel];
endmodule

// File: rtl/ide_dma_seq.sv
module ide_dma_seq
  import ide_dma_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             dir_i,
  input  logic             dmarq_i,
  input  logic [CNT_W-1:0] act_i,
  input  logic [CNT_W-1:0] rec_i,
  output logic             stb_o,
  output logic             dir_o,
  output logic             ack_o,
  output logic             xfer_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  seq_st_e          st_q;
  logic [CNT_W-1:0] cnt_q;
  logic             stb_q, ack_q, dir_q, xfer_q;
  logic             go;

  assign go = en_i & dmarq_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      stb_q  <= 1'b0;
      ack_q  <= 1'b0;
      dir_q  <= 1'b0;
      xfer_q <= 1'b0;
    end else begin
      xfer_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (go) begin
          st_q  <= ST_ACK;
          ack_q <= 1'b1;
          dir_q <= dir_i;
        end
        ST_ACK: begin
          st_q  <= ST_STRB;
          stb_q <= 1'b1;
          cnt_q <= act_i - ONE;
        end
        ST_STRB: begin
          if (cnt_q == '0) begin
            // request looked at only on this deassert edge
            stb_q  <= 1'b0;
            xfer_q <= 1'b1;
            cnt_q  <= rec_i - ONE;
            st_q   <= go ? ST_REC : ST_HOLD;
          end else begin
            cnt_q <= cnt_q - ONE;
          end
        end
        ST_REC: begin
          if (cnt_q == '0) begin
            st_q  <= ST_STRB;
            stb_q <= 1'b1;
            cnt_q <= act_i - ONE;
          end else begin
            cnt_q <= cnt_q - ONE;
          end
        end
        ST_HOLD: begin
          ack_q <= 1'b0;
          if (cnt_q == '0) st_q <= ST_IDLE;
          else             cnt_q <= cnt_q - ONE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign stb_o  = stb_q;
  assign ack_o  = ack_q;
  assign dir_o  = dir_q;
  assign xfer_o = xfer_q;

  assert_stb_in_ack_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_q |-> ack_q);
  assert_ack_leads_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stb_q) |-> $past(ack_q));
  assert_ack_drop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(stb_q) && !$past(go)) |=> !ack_q);
  assert_ack_kept_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(stb_q) && $past(go)) |=> ack_q);
  assert_xfer_on_end_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(stb_q) |-> xfer_q);
  assert_xfer_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_q |=> !xfer_q);
endmodule

// File: rtl/ide_strobe_steer.sv
module ide_strobe_steer (
  input  logic stb_i,
  input  logic dir_i,
  output logic dior_no,
  output logic diow_no
);
  logic [1:0] str_n;

  // index 0: read strobe, index 1: write strobe
  for (genvar i = 0; i < 2; i++) begin : g_str
    assign str_n[i] = !(stb_i && (dir_i == 1'(i)));
  end

  assign dior_no = str_n[0];
  assign diow_no = str_n[1];

  always_comb begin
    assert_no_dual_strobe_R3: assert (dior_no || diow_no);
  end
endmodule

// File: rtl/ide_dma_strobe_unit.sv
module ide_dma_strobe_unit
  import ide_dma_pkg::*;
#(
  parameter int ACT_MAX = 5,
  parameter int REC_MAX = 4,
  parameter int CNT_W   = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             dir_i,
  input  logic             dmarq_i,
  input  logic [TIM_W-1:0] timing_i,
  output logic             dior_no,
  output logic             diow_no,
  output logic             dmack_no,
  output logic             xfer_o
);
  logic [CNT_W-1:0] act_clks, rec_clks;
  logic             stb, dir_lat, ack;

  ide_tmg_sel #(.ACT_MAX(ACT_MAX), .REC_MAX(REC_MAX), .CNT_W(CNT_W)) u_sel (
    .tim_i (tim_reg_t'(timing_i)),
    .act_o (act_clks),
    .rec_o (rec_clks)
  );

  ide_dma_seq #(.CNT_W(CNT_W)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .dir_i   (dir_i),
    .dmarq_i (dmarq_i),
    .act_i   (act_clks),
    .rec_i   (rec_clks),
    .stb_o   (stb),
    .dir_o   (dir_lat),
    .ack_o   (ack),
    .xfer_o  (xfer_o)
  );

  ide_strobe_steer u_steer (
    .stb_i   (stb),
    .dir_i   (dir_lat),
    .dior_no (dior_no),
    .diow_no (diow_no)
  );

  assign dmack_no = ~ack;
endmodule

// File: tb/sim_ide_dma_strobe_unit.sv
module sim_ide_dma_strobe_unit;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_i = 1'b0;
  logic       dir_i = 1'b0;
  logic       dmarq_i = 1'b0;
  logic [4:0] timing_i = '0;
  logic       dior_no, diow_no, dmack_no, xfer_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit ended   = 0;

  always #4 clk_i = ~clk_i;

  ide_dma_strobe_unit u0 (
    .clk_i, .rst_ni, .en_i, .dir_i, .dmarq_i, .timing_i,
    .dior_no, .diow_no, .dmack_no, .xfer_o
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  task automatic run_burst(input int pio, input int fast, input int only,
                           input int d, input int nw);
    int m  = (only != 0) ? fast : pio;
    int ea = 5 - m;
    int er = 4 - m;
    int run = 0, hi = 0, words = 0, xf = 0, lead = 0, post = -1, guard = 0;
    int oth_seen = 0, ack_bad = 0, quiet_bad = 0;
    bit done = 0;
    bit sel, oth, ack;
    @(negedge clk_i);
    timing_i = {1'(only), 2'(fast), 2'(pio)};
    dir_i    = 1'(d);
    dmarq_i  = 1'b1;
    while (!done && guard < 400) begin
      @(negedge clk_i);
      guard++;
      sel = (d != 0) ? !diow_no : !dior_no;
      oth = (d != 0) ? !dior_no : !diow_no;
      ack = !dmack_no;
      if (xfer_o) xf++;
      if (oth) oth_seen++;
      if (post < 0) begin
        if (sel) begin
          if (run == 0) begin
            words++;
            if (words == 1) chk(lead == 1, "R2 ack lead", lead, 1);
            else            chk(hi == er, "R4 R5 recovery", hi, er);
          end
          run++;
          if (!ack) ack_bad++;
          if (run == 1) dmarq_i = 1'b0;        // last word: real drop; else glitch
          else if (run == 2 && words < nw) dmarq_i = 1'b1;
        end else begin
          if (run > 0) begin
            chk(run == ea, "R4 R5 active", run, ea);
            run = 0;
            hi  = 0;
            if (words == nw) begin
              post = 0;
              chk(ack, "R7 ack held", int'(ack), 1);
            end
          end
          hi++;
          if (words == 0 && ack) lead++;
        end
      end else begin
        post++;
        if (post == 1) chk(!ack, "R7 ack drop", int'(ack), 0);
        if (sel || oth || ack) quiet_bad++;
        if (post == 6) done = 1;
      end
    end
    chk(done, "R6 burst end", int'(done), 1);
    chk(words == nw, "R6 words", words, nw);
    chk(xf == nw, "R9 pulses", xf, nw);
    chk(oth_seen == 0, "R3 other strobe", oth_seen, 0);
    chk(ack_bad == 0, "R2 strobe w/o ack", ack_bad, 0);
    chk(quiet_bad == 0, "R8 quiet", quiet_bad, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk(dior_no && diow_no && dmack_no && !xfer_o, "R1 in reset",
        {dior_no, diow_no, dmack_no, xfer_o}, 4'b1110);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(dior_no && diow_no && dmack_no && !xfer_o, "R1 after reset",
        {dior_no, diow_no, dmack_no, xfer_o}, 4'b1110);

    // enable low: request must not start anything
    begin
      int busy = 0;
      dmarq_i = 1'b1;
      repeat (10) begin
        @(negedge clk_i);
        if (!dmack_no || !dior_no || !diow_no) busy++;
      end
      chk(busy == 0, "R2 enable gate", busy, 0);
      dmarq_i = 1'b0;
    end
    en_i = 1'b1;

    for (int pio = 0; pio < 4; pio++)
      for (int fast = 0; fast < 4; fast++)
        for (int only = 0; only < 2; only++)
          for (int d = 0; d < 2; d++)
            run_burst(pio, fast, only, d, 1 + ((pio + fast + only + d) % 3));

    // enable dropped mid-burst ends it like a request drop
    begin
      int low_cnt = 0;
      timing_i = 5'b0_00_11; // mode 3: 2 active clocks
      dir_i    = 1'b0;
      dmarq_i  = 1'b1;
      while (dior_no) @(negedge clk_i);
      en_i = 1'b0;
      @(negedge clk_i);
      @(negedge clk_i);
      chk(!dmack_no, "R7 en drop held", int'(!dmack_no), 1);
      @(negedge clk_i);
      chk(dmack_no, "R7 en drop release", int'(dmack_no), 1);
      repeat (8) begin
        @(negedge clk_i);
        if (!dior_no) low_cnt++;
      end
      chk(low_cnt == 0, "R2 no restart with en low", low_cnt, 0);
      dmarq_i = 1'b0;
    end
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: got 1 expected 0");
    finish_run();
  end
endmodule